// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation tree stored in memory. A root register gives the page frame of the top-level directory. The top ten address bits select a directory entry. That entry names the frame of a second-level table, and the next ten bits select an entry in that table. The table entry names the page frame. The low twelve bits pass through unchanged as the byte offset inside a 4 KiB page.

A client offers one request at a time on a valid/ready handshake. Each request carries the linear address and a flag that marks a write. The walker then issues at most two 32-bit reads, one after the other, on a read port with a fixed latency of one cycle. Directory and table entries share one format. The walker ends every request with a single-cycle `done` pulse. That pulse carries either the physical address or a fault cause. A fault is raised for a missing directory entry, a missing table entry, or a write to a page that is not writable. While a walk is in progress the walker takes no new request.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to byte address {root_base[31:12], linear[31:22], 2'b00}. The low 12 bits of `root_base` are ignored.
- R2: When the directory entry is present, the second read goes to {dir_entry[31:12], linear[21:12], 2'b00}.
- R3: An entry holds the frame number in bits 31:12, a present flag in bit 0 and a writable flag in bit 1. Bits 11:2 are reserved and have no effect on any result.
- R4: A directory entry with bit 0 clear ends the walk with cause 2'd1 after one read only. `done` rises in the third cycle after the accepting edge.
- R5: A table entry with bit 0 clear ends the walk with cause 2'd2.
- R6: A write to a page whose table entry has bit 1 clear faults with cause 2'd3. A read of that page succeeds. The writable bit of the directory entry has no effect.
- R7: A successful walk gives `phys_addr` = {table_entry[31:12], linear[11:0]}, with `done_fault` low and cause 2'd0. `done` rises in the fifth cycle after the accepting edge.
- R8: `req_ready` is high only when the walker is idle. A request offered while a walk is busy is ignored and does not change the result of that walk.
- R9: The walker asserts `mem_rd_en` for one cycle per entry read, beginning in the cycle after the accept. It samples the read data in the cycle that follows each read.
- R10: `done` is a one-cycle pulse. Outside that pulse, `done_fault`, `fault_cause` and `phys_addr` are zero. After reset, `req_ready` is 1 and both `done` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Physical address of the directory; bits 31:12 are used |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker is idle and will accept a request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_en | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read (4-byte aligned) |
| mem_rd_data | input | 32 | Entry word, valid the cycle after `mem_rd_en` |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | The completed walk faulted |
| fault_cause | output | 2 | 0 none, 1 directory missing, 2 table missing, 3 write protect |
| phys_addr | output | 32 | Translated address on a successful `done` |

## Verification
The bench drives directory misses on write requests. A walker that checks write permission too early, or that goes on to a second read, shows up there as a wrong cause or an extra memory read. It also sends reads and writes to read-only pages under directory entries that are themselves not writable. A design that applies the flag to the wrong level, or to reads, faults where it must not. Reserved bits are filled with noise and the root register carries nonzero low bits, so any of those bits leaking into an address shows up in the logged read addresses. The bench also holds a different request on the handshake during a walk and walks the highest directory and table index, which catches a walker that takes requests while busy or slices the indices wrongly.

// File: rtl/ptw_pkg.sv
// Shared definitions for the two-level page table walker.
// Assumes: entries carry the present flag and the writable flag at fixed low bits.
package ptw_pkg;
    localparam int ENT_PRESENT  = 0;
    localparam int ENT_WRITABLE = 1;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_DIR_MISSING = 2'd1,
        FLT_TBL_MISSING = 2'd2,
        FLT_WRITE_PROT  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WAIT,
        ST_TBL_RD,
        ST_TBL_WAIT
    } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Holds the linear address of the request in flight and the frame of the
// current table level, and forms the byte address of the next entry to read.
// Assumes: entries are 4 bytes and every table starts on a page boundary.
module ptw_addr_gen #(
    parameter int DIR_BITS = 10,
    parameter int TBL_BITS = 10,
    parameter int OFF_BITS = 12,
    localparam int ADDR_W  = DIR_BITS + TBL_BITS + OFF_BITS,
    localparam int FRAME_W = ADDR_W - OFF_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_req,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               load_frame,
    input  logic [FRAME_W-1:0] next_frame,
    input  logic               sel_tbl,
    output logic [ADDR_W-1:0]  entry_addr,
    output logic [OFF_BITS-1:0] page_off
);
    logic [ADDR_W-1:0]  la_q;
    logic [FRAME_W-1:0] frame_q;
    logic [ADDR_W-1:0]  idx_ext;

    // Capture the request address and root frame, then the frame of the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q    <= '0;
            frame_q <= '0;
        end else if (load_req) begin
            la_q    <= req_addr;
            frame_q <= root_frame;
        end else if (load_frame) begin
            frame_q <= next_frame;
        end
    end

    // Pick the index field for the level being read.
    always_comb begin
        if (sel_tbl)
            idx_ext = ADDR_W'(la_q[OFF_BITS+TBL_BITS-1:OFF_BITS]);
        else
            idx_ext = ADDR_W'(la_q[ADDR_W-1:OFF_BITS+TBL_BITS]);
    end

    // The entry address is the table base plus the index times four.
    always_comb begin
        entry_addr = {frame_q, {OFF_BITS{1'b0}}} + (idx_ext << 2);
    end

    assign page_off = la_q[OFF_BITS-1:0];
endmodule

// File: rtl/ptw_entry_check.sv
// Decodes the flag bits of one fetched entry and names the fault, if any.
// Assumes: write permission is enforced at the table level only.
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic   ent_present,
    input  logic   ent_writable,
    input  logic   is_table_level,
    input  logic   access_write,
    output fault_e cause
);
    // Classify the entry as missing, write-protected, or usable.
    always_comb begin
        if (!ent_present)
            cause = is_table_level ? FLT_TBL_MISSING : FLT_DIR_MISSING;
        else if (is_table_level && access_write && !ent_writable)
            cause = FLT_WRITE_PROT;
        else
            cause = FLT_NONE;
    end
endmodule

// File: rtl/ptw_walk_fsm.sv
// Steps one walk through the directory read, the table read and the report.
// Assumes: the read data is valid exactly one cycle after each read request.
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  fault_e             chk_cause,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic               req_ready,
    output logic               load_req,
    output logic               load_frame,
    output logic               sel_tbl,
    output logic               is_table_level,
    output logic               access_write,
    output logic               mem_rd_en,
    output logic               done,
    output logic               done_fault,
    output fault_e             cause_q,
    output logic [FRAME_W-1:0] res_frame
);
    walk_st_e st;

    // Advance the walk and register the one-cycle result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            access_write <= 1'b0;
            done         <= 1'b0;
            done_fault   <= 1'b0;
            cause_q      <= FLT_NONE;
            res_frame    <= '0;
        end else begin
            done       <= 1'b0;
            done_fault <= 1'b0;
            cause_q    <= FLT_NONE;
            res_frame  <= '0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        access_write <= req_write;
                        st           <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: st <= ST_DIR_WAIT;
                ST_DIR_WAIT: begin
                    if (chk_cause != FLT_NONE) begin
                        done       <= 1'b1;
                        done_fault <= 1'b1;
                        cause_q    <= chk_cause;
                        st         <= ST_IDLE;
                    end else begin
                        st <= ST_TBL_RD;
                    end
                end
                ST_TBL_RD: st <= ST_TBL_WAIT;
                ST_TBL_WAIT: begin
                    done       <= 1'b1;
                    done_fault <= (chk_cause != FLT_NONE);
                    cause_q    <= chk_cause;
                    if (chk_cause == FLT_NONE)
                        res_frame <= ent_frame;
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode the strobes for the handshake, the address former and the memory.
    always_comb begin
        req_ready      = (st == ST_IDLE);
        load_req       = (st == ST_IDLE) && req_valid;
        load_frame     = (st == ST_DIR_WAIT) && (chk_cause == FLT_NONE);
        sel_tbl        = (st == ST_TBL_RD);
        is_table_level = (st == ST_TBL_WAIT);
        mem_rd_en      = (st == ST_DIR_RD) || (st == ST_TBL_RD);
    end

    a_r9_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);
    a_r9_single_cycle_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker: accepts one translation at a time, reads the
// directory entry and then the table entry, and reports an address or a fault.
// Assumes: a read port with one-cycle latency and word-aligned byte addresses.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int DIR_BITS = 10,
    parameter int TBL_BITS = 10,
    parameter int OFF_BITS = 12,
    localparam int ADDR_W  = DIR_BITS + TBL_BITS + OFF_BITS,
    localparam int FRAME_W = ADDR_W - OFF_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              done,
    output logic              done_fault,
    output logic [1:0]        fault_cause,
    output logic [ADDR_W-1:0] phys_addr
);
    logic               load_req, load_frame, sel_tbl, is_table_level, access_write;
    fault_e             chk_cause, cause_q;
    logic [FRAME_W-1:0] res_frame;
    logic [OFF_BITS-1:0] page_off;
    logic               unused_low_bits;

    assign unused_low_bits = ^{root_base[OFF_BITS-1:0], mem_rd_data[OFF_BITS-1:2]};

    ptw_addr_gen #(
        .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS), .OFF_BITS(OFF_BITS)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .req_addr   (req_addr),
        .root_frame (root_base[ADDR_W-1:OFF_BITS]),
        .load_frame (load_frame),
        .next_frame (mem_rd_data[ADDR_W-1:OFF_BITS]),
        .sel_tbl    (sel_tbl),
        .entry_addr (mem_rd_addr),
        .page_off   (page_off)
    );

    ptw_entry_check u_check (
        .ent_present    (mem_rd_data[ENT_PRESENT]),
        .ent_writable   (mem_rd_data[ENT_WRITABLE]),
        .is_table_level (is_table_level),
        .access_write   (access_write),
        .cause          (chk_cause)
    );

    ptw_walk_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .chk_cause      (chk_cause),
        .ent_frame      (mem_rd_data[ADDR_W-1:OFF_BITS]),
        .req_ready      (req_ready),
        .load_req       (load_req),
        .load_frame     (load_frame),
        .sel_tbl        (sel_tbl),
        .is_table_level (is_table_level),
        .access_write   (access_write),
        .mem_rd_en      (mem_rd_en),
        .done           (done),
        .done_fault     (done_fault),
        .cause_q        (cause_q),
        .res_frame      (res_frame)
    );

    // Present the result only during a successful completion pulse.
    always_comb begin
        fault_cause = cause_q;
        phys_addr   = (done && !done_fault) ? {res_frame, page_off} : '0;
    end

    // R4: a directory-missing report follows a fetched word with bit 0 clear.
    a_r4_dir_miss_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause == FLT_DIR_MISSING) |-> !$past(mem_rd_data[ENT_PRESENT]));
    // R7: the offset comes from the request accepted five cycles earlier.
    a_r7_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> phys_addr[OFF_BITS-1:0] == $past(req_addr[OFF_BITS-1:0], 5));
    // R6: a write-protect report only ever follows a write request.
    a_r6_wp_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cause == FLT_WRITE_PROT) |-> $past(req_write, 5));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = 32'h0000_5ABC;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        done, done_fault;
    logic [1:0]  fault_cause;
    logic [31:0] phys_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [8];
    int          rd_n = 0;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .done_fault(done_fault),
        .fault_cause(fault_cause), .phys_addr(phys_addr)
    );

    function automatic logic [31:0] mread(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mread(mem_rd_addr);
            if (rd_n < 8) rd_log[rd_n] = mem_rd_addr;
            rd_n = rd_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the walk from the requirements: addresses, result, latency.
    task automatic model(input logic [31:0] la, input bit wr, output logic [31:0] a0,
                         output logic [31:0] a1, output int nrd, output logic [1:0] cause,
                         output logic [31:0] pa, output int lat);
        logic [31:0] de, te;
        a0 = {root_base[31:12], la[31:22], 2'b00};
        de = mread(a0);
        a1 = '0; pa = '0;
        if (!de[0]) begin
            cause = 2'd1; nrd = 1; lat = 3;
        end else begin
            a1 = {de[31:12], la[21:12], 2'b00};
            te = mread(a1);
            nrd = 2; lat = 5;
            if (!te[0]) cause = 2'd2;
            else if (wr && !te[1]) cause = 2'd3;
            else begin cause = 2'd0; pa = {te[31:12], la[11:0]}; end
        end
    endtask

    task automatic walk(input logic [31:0] la, input bit wr, input bit poke);
        logic [31:0] a0, a1, pa;
        int nrd, lat, n;
        logic [1:0] cause;
        model(la, wr, a0, a1, nrd, cause, pa, lat);
        @(negedge clk);
        rd_n = 0;
        req_addr = la; req_write = wr; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R8 ready when idle", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        if (poke) begin
            req_addr = ~la; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        n = 1;
        while (done !== 1'b1 && n < 12) begin
            chk(req_ready === 1'b0, "R8 not ready while busy", {31'b0, req_ready}, 32'h0);
            chk(done_fault === 1'b0 && phys_addr === 32'h0, "R10 outputs idle before done", phys_addr, 32'h0);
            @(negedge clk);
            n++;
            if (n == 2) req_valid = 1'b0;
        end
        chk(n == lat, (lat == 3) ? "R4 done latency" : "R7 done latency", n, lat);
        chk(fault_cause === cause, "R4 R5 R6 fault cause", {30'b0, fault_cause}, {30'b0, cause});
        chk(done_fault === (cause != 2'd0), "R6 fault flag", {31'b0, done_fault}, {31'b0, cause != 2'd0});
        chk(phys_addr === pa, "R7 physical address", phys_addr, pa);
        chk(rd_n == nrd, "R9 number of reads", rd_n, nrd);
        chk(rd_log[0] === a0, "R1 directory entry address", rd_log[0], a0);
        if (nrd == 2) chk(rd_log[1] === a1, "R2 table entry address", rd_log[1], a1);
        @(negedge clk);
        chk(done === 1'b0 && phys_addr === 32'h0, "R10 done is one cycle", {31'b0, done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] dbase;
        void'($urandom(32'd2024));
        dbase = {root_base[31:12], 12'h000};
        // Directory: indices 0..15 except every fourth is missing; reserved bits noisy (R3).
        for (int d = 0; d < 16; d++) begin
            if (d % 4 != 3)
                mem[dbase + d*4] = {20'(32'h100 + d), 10'($urandom), 1'($urandom), 1'b1};
            else
                mem[dbase + d*4] = {20'(32'h300 + d), 10'($urandom), 1'($urandom), 1'b0};
            for (int t = 0; t < 32; t++)
                mem[{20'(32'h100 + d), 12'h0} + t*4] =
                    {20'($urandom), 10'($urandom), 1'($urandom), 1'($urandom % 5 != 0)};
        end
        // R6: directory 0 not writable; its table entry 0 writable, entry 1 read-only.
        mem[dbase] = {20'h00100, 10'h3FF, 1'b0, 1'b1};
        mem[32'h0010_0000] = {20'h12345, 10'h155, 1'b1, 1'b1};
        mem[32'h0010_0004] = {20'h54321, 10'h2AA, 1'b0, 1'b1};
        // Highest indices of both levels.
        mem[dbase + 1023*4] = {20'h00200, 10'h0, 1'b1, 1'b1};
        mem[32'h0020_0000 + 1023*4] = {20'hABCDE, 10'h0, 1'b1, 1'b1};

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 reset ready", {31'b0, req_ready}, 32'h1);
        chk(done === 1'b0, "R10 reset done", {31'b0, done}, 32'h0);
        chk(mem_rd_en === 1'b0, "R10 reset read enable", {31'b0, mem_rd_en}, 32'h0);
        rst_n = 1'b1;

        walk({10'd3, 10'd5, 12'h123}, 1'b1, 1'b0);   // R4 directory missing on a write
        walk({10'd0, 10'd0, 12'hFED}, 1'b1, 1'b0);   // R6 dir not writable, page writable
        walk({10'd0, 10'd1, 12'h010}, 1'b0, 1'b0);   // R6 read-only page read
        walk({10'd0, 10'd1, 12'h010}, 1'b1, 1'b0);   // R6 read-only page write
        walk({10'd0, 10'd40, 12'h0}, 1'b0, 1'b0);    // R5 table entry absent
        walk(32'hFFFF_FFFF, 1'b1, 1'b0);             // R1 R2 top indices
        walk({10'd1, 10'd2, 12'h777}, 1'b0, 1'b1);   // R8 request held while busy
        walk({10'd7, 10'd9, 12'h001}, 1'b1, 1'b1);   // R8 poke during a miss
        for (int i = 0; i < 150; i++) begin
            walk({10'($urandom % 16), 10'($urandom % 40), 12'($urandom)},
                 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule